// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits in front of a double-precision fused multiply-add unit computing z + x*y, or z - x*y when the product-negate input is high. It sorts each of the three operands into one of six classes: zero, normal, denormal, infinity, quiet NaN or signalling NaN. From those classes it decides whether the answer is already fixed by the operands alone.

When the answer is fixed, the block drives that final result and the invalid-operation flag, and raises the special-result strobe. Otherwise it raises the datapath-request flag, which tells the arithmetic pipeline to do the real multiply and add. Rounding, denormal normalisation and trapping are left to the surrounding logic. The outputs are registered, so a decision appears one clock after its operands.

Operand layout follows IEEE-754 binary64: the sign is in bit 63, the biased exponent in bits 62:52 and the fraction in bits 51:0. A NaN whose fraction MSB (bit 51) is 1 is quiet. A NaN with that bit at 0 and a nonzero fraction is signalling.

Top module: `fma_special_resolver`

## Requirements
- R1: After each clock, exactly one of `special_o` and `use_dp_o` is high. `use_dp_o` is high exactly when the following all hold: no operand is a NaN, x and y are both finite and nonzero, and z is finite. When it is high, `result_o` is 0 and `invalid_o` is 0.
- R2: When any operand is a NaN, a signalling NaN is chosen before any quiet NaN. Among NaNs of the same kind, z comes first, then x, then y.
- R3: A chosen signalling NaN is returned with bit 51 set and its other bits unchanged, and `invalid_o` is 1.
- R4: A chosen quiet NaN is returned bit for bit, and `invalid_o` is 0.
- R5: When there is no NaN and one of x and y is infinite while the other is zero, in either order, the result is the default NaN parameter `DEF_NAN` (default 64'h7FF8000000000000) and `invalid_o` is 1.
- R6: With no NaN, an infinite product (one of x and y infinite, the other nonzero) and an infinite z whose sign differs from the effective product sign, the result is `DEF_NAN` and `invalid_o` is 1. The effective product sign is x[63]^y[63], inverted when `neg_prod_i` is 1.
- R7: In any other case with an infinite product, the result is an infinity carrying the effective product sign, and `invalid_o` is 0.
- R8: With no NaN and a zero product (x or y zero, the other finite), the result is z bit for bit and `invalid_o` is 0. When z is infinite, this gives an infinity with z's sign.
- R9: When x and y are finite and nonzero and z is infinite, the result is z, an infinity with z's sign, and `invalid_o` is 0.
- R10: Outputs change only one rising clock after the inputs change. While `rst_ni` is low, `special_o`=1, `result_o`=0, `invalid_o`=0 and `use_dp_o`=0.
- R11: Denormal x or y counts as finite and nonzero. A denormal product with a finite z therefore requests the datapath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| z_i | input | 64 | Addend |
| x_i | input | 64 | First multiplicand |
| y_i | input | 64 | Second multiplicand |
| neg_prod_i | input | 1 | 1 selects z - x*y |
| special_o | output | 1 | Result is final |
| result_o | output | 64 | Final result when special_o is high |
| invalid_o | output | 1 | Invalid-operation flag |
| use_dp_o | output | 1 | Arithmetic datapath must compute the result |

## Verification
The bench builds the block with its default binary64 widths, EXP_W=11 and FRAC_W=52, and the default quiet NaN 64'h7FF8000000000000. At these values it can compare results against hand-written binary64 encodings. Among them are signalling NaNs whose fraction lies only in the low bits, which makes it visible whether the quieting bit was added. The tests place NaNs of both kinds in every operand position to exercise the z, x, y order. They also cross-check the infinity sign against both settings of the product-negate input.

// File: rtl/fma_spec_pkg.sv
package fma_spec_pkg;
  typedef enum logic [2:0] {
    CL_ZERO   = 3'd0,
    CL_NORM   = 3'd1,
    CL_DENORM = 3'd2,
    CL_INF    = 3'd3,
    CL_QNAN   = 3'd4,
    CL_SNAN   = 3'd5
  } opnd_class_e;
endpackage

// File: rtl/fma_opnd_class.sv
module fma_opnd_class
  import fma_spec_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_i,
  output opnd_class_e  cls_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max, exp_min, frac_zero;

  assign exp_f     = op_i[W-2 -: EXP_W];
  assign frac_f    = op_i[FRAC_W-1:0];
  assign exp_max   = &exp_f;
  assign exp_min   = ~|exp_f;
  assign frac_zero = ~|frac_f;

  always_comb begin
    if (exp_max) begin
      if (frac_zero)                cls_o = CL_INF;
      else if (frac_f[FRAC_W-1])    cls_o = CL_QNAN;
      else                          cls_o = CL_SNAN;
    end else if (exp_min) begin
      cls_o = frac_zero ? CL_ZERO : CL_DENORM;
    end else begin
      cls_o = CL_NORM;
    end
  end
endmodule

// File: rtl/fma_nan_pick.sv
module fma_nan_pick
  import fma_spec_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int N_OPS  = 3,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic [N_OPS-1:0][W-1:0] ops_i,   // index 0 has highest priority
  input  opnd_class_e             cls_i [N_OPS],
  output logic                    hit_o,
  output logic [W-1:0]            res_o,
  output logic                    invalid_o
);
  localparam logic [W-1:0] QUIET_BIT = W'(1) << (FRAC_W - 1);

  always_comb begin
    hit_o     = 1'b0;
    res_o     = '0;
    invalid_o = 1'b0;
    // scan low priority first so the highest-priority hit is written last
    for (int i = N_OPS - 1; i >= 0; i--) begin
      if (cls_i[i] == CL_QNAN) begin
        hit_o     = 1'b1;
        res_o     = ops_i[i];
        invalid_o = 1'b0;
      end
    end
    for (int i = N_OPS - 1; i >= 0; i--) begin
      if (cls_i[i] == CL_SNAN) begin
        hit_o     = 1'b1;
        res_o     = ops_i[i] | QUIET_BIT;
        invalid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fma_infzero_resolve.sv
module fma_infzero_resolve
  import fma_spec_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter logic [EXP_W+FRAC_W:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}},
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  opnd_class_e  z_cls_i,
  input  opnd_class_e  x_cls_i,
  input  opnd_class_e  y_cls_i,
  input  logic [W-1:0] z_i,
  input  logic         prod_sign_i,
  output logic         hit_o,
  output logic [W-1:0] res_o,
  output logic         invalid_o
);
  logic x_inf, y_inf, x_zero, y_zero, z_inf;

  assign x_inf  = (x_cls_i == CL_INF);
  assign y_inf  = (y_cls_i == CL_INF);
  assign x_zero = (x_cls_i == CL_ZERO);
  assign y_zero = (y_cls_i == CL_ZERO);
  assign z_inf  = (z_cls_i == CL_INF);

  always_comb begin
    hit_o     = 1'b1;
    res_o     = '0;
    invalid_o = 1'b0;
    if (x_inf || y_inf) begin
      if (x_zero || y_zero) begin
        res_o     = DEF_NAN;
        invalid_o = 1'b1;
      end else if (z_inf && (z_i[W-1] != prod_sign_i)) begin
        res_o     = DEF_NAN;
        invalid_o = 1'b1;
      end else begin
        res_o = {prod_sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end
    end else if (x_zero || y_zero || z_inf) begin
      // zero product, or finite product swamped by infinite z: z passes
      res_o = z_i;
    end else begin
      hit_o = 1'b0;
    end
  end
endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
  import fma_spec_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter logic [EXP_W+FRAC_W:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}},
  localparam int W = 1 + EXP_W + FRAC_W,
  localparam int N_OPS = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] z_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         neg_prod_i,
  output logic         special_o,
  output logic [W-1:0] result_o,
  output logic         invalid_o,
  output logic         use_dp_o
);
  logic [N_OPS-1:0][W-1:0] ops;
  opnd_class_e             cls [N_OPS];

  assign ops = {y_i, x_i, z_i};

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fma_opnd_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op_i  (ops[g]),
      .cls_o (cls[g])
    );
  end

  logic         nan_hit, nan_inv;
  logic [W-1:0] nan_res;
  fma_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .N_OPS(N_OPS)) u_nan (
    .ops_i     (ops),
    .cls_i     (cls),
    .hit_o     (nan_hit),
    .res_o     (nan_res),
    .invalid_o (nan_inv)
  );

  logic         prod_sign;
  logic         iz_hit, iz_inv;
  logic [W-1:0] iz_res;
  assign prod_sign = x_i[W-1] ^ y_i[W-1] ^ neg_prod_i;

  fma_infzero_resolve #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .DEF_NAN(DEF_NAN)) u_iz (
    .z_cls_i     (cls[0]),
    .x_cls_i     (cls[1]),
    .y_cls_i     (cls[2]),
    .z_i         (z_i),
    .prod_sign_i (prod_sign),
    .hit_o       (iz_hit),
    .res_o       (iz_res),
    .invalid_o   (iz_inv)
  );

  logic         spec_d, inv_d;
  logic [W-1:0] res_d;
  always_comb begin
    if (nan_hit) begin
      spec_d = 1'b1; res_d = nan_res; inv_d = nan_inv;
    end else if (iz_hit) begin
      spec_d = 1'b1; res_d = iz_res;  inv_d = iz_inv;
    end else begin
      spec_d = 1'b0; res_d = '0;      inv_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      special_o <= 1'b1;
      result_o  <= '0;
      invalid_o <= 1'b0;
      use_dp_o  <= 1'b0;
    end else begin
      special_o <= spec_d;
      result_o  <= res_d;
      invalid_o <= inv_d;
      use_dp_o  <= ~spec_d;
    end
  end
endmodule

// File: rtl/fma_special_resolver_chk.sv
module fma_special_resolver_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter logic [EXP_W+FRAC_W:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}},
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] z_i,
  input logic [W-1:0] x_i,
  input logic [W-1:0] y_i,
  input logic         neg_prod_i,
  input logic         special_o,
  input logic [W-1:0] result_o,
  input logic         invalid_o,
  input logic         use_dp_o
);
  function automatic logic f_nan(input logic [W-1:0] v);
    return (&v[W-2 -: EXP_W]) && (|v[FRAC_W-1:0]);
  endfunction
  function automatic logic f_snan(input logic [W-1:0] v);
    return f_nan(v) && !v[FRAC_W-1];
  endfunction
  function automatic logic f_inf(input logic [W-1:0] v);
    return (&v[W-2 -: EXP_W]) && !(|v[FRAC_W-1:0]);
  endfunction
  function automatic logic f_zero(input logic [W-1:0] v);
    return !(|v[W-2:0]);
  endfunction

  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  logic any_snan, any_nan, inf_x_zero;
  assign any_snan   = f_snan(z_i) || f_snan(x_i) || f_snan(y_i);
  assign any_nan    = f_nan(z_i) || f_nan(x_i) || f_nan(y_i);
  assign inf_x_zero = (f_inf(x_i) && f_zero(y_i)) || (f_zero(x_i) && f_inf(y_i));

  a_r1_one_of_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    special_o != use_dp_o);

  a_r1_dp_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_dp_o |-> (!invalid_o && result_o == '0));

  a_r3_snan_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(any_snan)) |-> (special_o && invalid_o && result_o[FRAC_W-1]));

  a_r4_qnan_z_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(!any_snan && f_nan(z_i))) |-> (result_o == $past(z_i) && !invalid_o));

  a_r5_inf_times_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(!any_nan && inf_x_zero)) |-> (invalid_o && result_o == DEF_NAN));

  a_r10_stable_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(primed) && $stable(z_i) && $stable(x_i) && $stable(y_i) && $stable(neg_prod_i))
      |=> $stable(result_o));
endmodule

bind fma_special_resolver fma_special_resolver_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .DEF_NAN(DEF_NAN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .z_i(z_i), .x_i(x_i), .y_i(y_i),
  .neg_prod_i(neg_prod_i), .special_o(special_o), .result_o(result_o),
  .invalid_o(invalid_o), .use_dp_o(use_dp_o)
);

// File: tb/fma_special_resolver_bench.sv
module fma_special_resolver_bench;
  localparam int CLK_PERIOD = 10;

  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] MONE = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] DEN  = 64'h0000_0000_0000_0001;
  localparam logic [63:0] S1   = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] S2   = 64'hFFF0_0000_0000_0002;
  localparam logic [63:0] S3   = 64'h7FF0_0000_0000_0003;
  localparam logic [63:0] Q1   = 64'hFFF8_0000_0000_0011;
  localparam logic [63:0] Q2   = 64'h7FF8_0000_0000_0022;
  localparam logic [63:0] Q3   = 64'h7FF8_0000_0000_0033;
  localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] z = '0, x = '0, y = '0;
  logic        neg = 1'b0;
  logic        spec, inv, use_dp;
  logic [63:0] res;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fma_special_resolver u_fma_special_resolver (
    .clk_i(clk), .rst_ni(rst_n), .z_i(z), .x_i(x), .y_i(y), .neg_prod_i(neg),
    .special_o(spec), .result_o(res), .invalid_o(inv), .use_dp_o(use_dp)
  );

  task automatic check(input string req, input logic e_spec, input logic [63:0] e_res,
                       input logic e_inv, input logic e_dp);
    n_chk++;
    if (spec !== e_spec || res !== e_res || inv !== e_inv || use_dp !== e_dp) begin
      n_fail++;
      $display("FAIL %s: got spec=%b res=%h inv=%b dp=%b, expected spec=%b res=%h inv=%b dp=%b",
               req, spec, res, inv, use_dp, e_spec, e_res, e_inv, e_dp);
    end
  endtask

  // inputs driven at a falling edge, checked at the next falling edge
  task automatic run(input string req, input logic [63:0] zz, xx, yy, input logic nn,
                     input logic e_spec, input logic [63:0] e_res, input logic e_inv);
    z = zz; x = xx; y = yy; neg = nn;
    @(negedge clk);
    check(req, e_spec, e_res, e_inv, ~e_spec);
  endtask

  task automatic t_reset;
    check("R10 reset", 1'b1, 64'h0, 1'b0, 1'b0);
  endtask

  task automatic t_nan_order;
    run("R2 sNaN beats quiet z", Q3, S1, Q2, 1'b0, 1'b1, 64'h7FF8_0000_0000_0001, 1'b1);
    run("R2 x sNaN over y sNaN", ONE, S1, S2, 1'b0, 1'b1, 64'h7FF8_0000_0000_0001, 1'b1);
    run("R2 z sNaN over x sNaN", S3, S1, ONE, 1'b0, 1'b1, 64'h7FF8_0000_0000_0003, 1'b1);
    run("R3 y sNaN quieted", ONE, ONE, S2, 1'b0, 1'b1, 64'hFFF8_0000_0000_0002, 1'b1);
    run("R4 z qNaN first", Q3, Q1, Q2, 1'b0, 1'b1, Q3, 1'b0);
    run("R4 x qNaN over y", ONE, Q1, Q2, 1'b1, 1'b1, Q1, 1'b0);
    run("R4 qNaN over inf*0", Q2, PINF, PZ, 1'b0, 1'b1, Q2, 1'b0);
  endtask

  task automatic t_infinity;
    run("R5 inf*0", ONE, PINF, PZ, 1'b0, 1'b1, DNAN, 1'b1);
    run("R5 -0*-inf", ONE, NZ, NINF, 1'b1, 1'b1, DNAN, 1'b1);
    run("R6 +inf*+inf + -inf", NINF, PINF, PINF, 1'b0, 1'b1, DNAN, 1'b1);
    run("R6 negated vs +inf z", PINF, PINF, ONE, 1'b1, 1'b1, DNAN, 1'b1);
    run("R7 negated sign", PZ, PINF, ONE, 1'b1, 1'b1, NINF, 1'b0);
    run("R7 same-sign inf z", PINF, NINF, MONE, 1'b0, 1'b1, PINF, 1'b0);
    run("R7 finite z", ONE, PINF, ONE, 1'b0, 1'b1, PINF, 1'b0);
  endtask

  task automatic t_zero_and_z;
    run("R8 denormal z kept", DEN, PZ, ONE, 1'b0, 1'b1, DEN, 1'b0);
    run("R8 inf z zero product", NINF, PZ, PZ, 1'b0, 1'b1, NINF, 1'b0);
    run("R8 negated zero product", ONE, ONE, NZ, 1'b1, 1'b1, ONE, 1'b0);
    run("R9 inf z finite product", NINF, ONE, ONE, 1'b0, 1'b1, NINF, 1'b0);
    run("R9 inf z denorm product", PINF, DEN, ONE, 1'b1, 1'b1, PINF, 1'b0);
  endtask

  task automatic t_datapath;
    run("R1 normal operands", ONE, ONE, ONE, 1'b0, 1'b0, 64'h0, 1'b0);
    run("R11 denormal product", PZ, DEN, DEN, 1'b1, 1'b0, 64'h0, 1'b0);
  endtask

  task automatic t_latency;
    run("R10 prime", ONE, ONE, ONE, 1'b0, 1'b0, 64'h0, 1'b0);
    z = ONE; x = PINF; y = PZ; neg = 1'b0;
    #1;
    check("R10 no change before edge", 1'b0, 64'h0, 1'b0, 1'b1);
    @(negedge clk);
    check("R10 change after edge", 1'b1, DNAN, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_nan_order();
    t_infinity();
    t_zero_and_z();
    t_datapath();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule